// File: doc/BRIEF.md
# Supervisor-Gated Interrupt Watchdog

This block protects a preemptive kernel running on a small 8-bit processor from user programs that mask interrupts, halt the processor, or wait with interrupts masked. Two timers run side by side. A long watchdog timer is held at zero whenever the processor is in supervisor mode and is restarted by a kick strobe written from the periodic timer-interrupt handler. If it runs out, it first pulls the non-maskable interrupt line low so that a handler can unmask interrupts again. If no kick follows and it runs out again, it forces a processor reset.

A second, much shorter latency timer counts only while the interrupt request line is asserted and the processor is in user mode. If a pending request stays unserviced for that long, it forces a reset at once, so that the kernel can remove the offending process. A small cause register records which timer fired. This block's own power-on reset clears it, the reset that the block forces does not, and the kernel clears it with a supervisor-mode write.

Control is a three-state machine. ARMED is the normal state. On a watchdog expiry it issues NMI and moves to ESCALATED. From ESCALATED a kick returns it to ARMED. Any latency expiry, and a watchdog expiry while ESCALATED, moves it to FORCING_RESET. When the reset pulse has been held for its full length, FORCING_RESET returns to ARMED. Every expiry restarts both timers.

Top module: `irq_guard`

## Requirements
- R1: While `sup_mode_i` is 1, the watchdog timer is held at zero and produces no NMI or reset, whatever `irq_n_i` and `kick_i` do.
- R2: In user mode, `kick_i` high for one cycle restarts the watchdog timer. A watchdog expiry happens on the WDOG_CYCLES-th consecutive user-mode cycle without a kick, and its effect shows at the outputs from the next clock edge on.
- R3: A watchdog expiry in ARMED drives `nmi_n_o` low for exactly NMI_CYCLES cycles and enters ESCALATED.
- R4: A watchdog expiry in ESCALATED drives `rst_n_o` low. Only a kick returns ESCALATED to ARMED. Time spent in supervisor mode does not.
- R5: The latency timer counts only in cycles with `irq_n_i` low (asserted) and `sup_mode_i` 0, and restarts in any other cycle. On its LAT_CYCLES-th consecutive counting cycle it forces a reset from either ARMED or ESCALATED.
- R6: A forced reset holds `rst_n_o` low for exactly RST_CYCLES cycles. Both timers stay at zero during that time, and the machine then returns to ARMED.
- R7: Every expiry (NMI or reset) restarts both timers from zero.
- R8: `cause_o` bit 0 is set by a watchdog NMI, bit 1 by a watchdog reset and bit 2 by a latency reset. The bits are sticky and survive the forced reset. `cause_clr_i` clears them only when `sup_mode_i` is 1, and a new setting in the same cycle wins over the clear.
- R9: When both timers expire in the same cycle in ARMED, the reset wins and no NMI is issued. `nmi_n_o` is never low while `rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset of this block, active low |
| sup_mode_i | input | 1 | Processor is in supervisor mode |
| irq_n_i | input | 1 | Interrupt request level, active low |
| kick_i | input | 1 | One-cycle restart strobe from the timer handler |
| cause_clr_i | input | 1 | Clear request for the cause register (honoured in supervisor mode only) |
| nmi_n_o | output | 1 | Non-maskable interrupt request, active low |
| rst_n_o | output | 1 | Forced processor reset, active low |
| cause_o | output | 3 | Sticky expiry causes: bit2 latency reset, bit1 watchdog reset, bit0 watchdog NMI |

## Verification
A wrong state or a wrong timer value always shows up as an NMI or a reset edge that comes too early, too late or of the wrong kind. The bench therefore predicts the exact cycle and pulse length of every edge and flags any edge it did not predict. A stuck escalation state shows up one watchdog period after the first NMI, as a reset where a second NMI was due, or the reverse. A timer that fails to restart after an expiry shows up within one latency period, because the latency reset then comes early. Cause-register errors are visible in the cycle after the write or expiry that should change it.

// File: rtl/irq_guard_pkg.sv
package irq_guard_pkg;

    typedef enum logic [1:0] {
        GS_ARMED = 2'd0,
        GS_ESCAL = 2'd1,
        GS_RESET = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic lat_rst;
        logic wd_rst;
        logic wd_nmi;
    } cause_t;

    // Bits needed to hold the values 0 .. limit-1
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/irq_guard_counter.sv
module irq_guard_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic expire
);
    localparam int W = irq_guard_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry on the LIMIT-th consecutive enabled cycle
    assign expire = en && (cnt_q == LAST);

endmodule

// File: rtl/irq_guard_pulse.sv
module irq_guard_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic active
);
    localparam int W = irq_guard_pkg::cnt_width(LEN + 1);
    localparam logic [W-1:0] LOAD = W'(LEN);

    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (abort) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/irq_guard_fsm.sv
module irq_guard_fsm
    import irq_guard_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wd_exp,
    input  logic         lat_exp,
    input  logic         kick,
    output logic         in_reset,
    output logic         nmi_fire,
    output logic         nmi_abort,
    output cause_t       cause_set
);
    localparam int HW = cnt_width(RST_CYCLES);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_CYCLES - 1);

    guard_state_e state_q, state_d;
    logic [HW-1:0] hold_q;
    logic          hold_done;

    assign hold_done = (hold_q == HOLD_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Reset-pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q == GS_RESET) begin
            hold_q <= hold_q + 1'b1;
        end else begin
            hold_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_ARMED: begin
                if (lat_exp)     state_d = GS_RESET;
                else if (wd_exp) state_d = GS_ESCAL;
            end
            GS_ESCAL: begin
                if (lat_exp || wd_exp) state_d = GS_RESET;
                else if (kick)         state_d = GS_ARMED;
            end
            GS_RESET: begin
                if (hold_done) state_d = GS_ARMED;
            end
            default: state_d = GS_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        in_reset          = (state_q == GS_RESET);
        nmi_fire          = (state_q == GS_ARMED) && wd_exp && !lat_exp;
        nmi_abort         = (state_q != GS_RESET) && (state_d == GS_RESET);
        cause_set.wd_nmi  = nmi_fire;
        cause_set.wd_rst  = (state_q == GS_ESCAL) && wd_exp;
        cause_set.lat_rst = (state_q != GS_RESET) && lat_exp;
    end

endmodule

// File: rtl/irq_guard_cause.sv
module irq_guard_cause
    import irq_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sup,
    input  logic   clr_req,
    input  cause_t set,
    output cause_t cause
);
    cause_t cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (clr_req && sup) begin
            cause_q <= set;
        end else begin
            cause_q <= cause_q | set;
        end
    end

    assign cause = cause_q;

endmodule

// File: rtl/irq_guard.sv
module irq_guard #(
    parameter int WDOG_CYCLES = 1_000_000,
    parameter int LAT_CYCLES  = 2_000,
    parameter int RST_CYCLES  = 16,
    parameter int NMI_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_mode_i,
    input  logic       irq_n_i,
    input  logic       kick_i,
    input  logic       cause_clr_i,
    output logic       nmi_n_o,
    output logic       rst_n_o,
    output logic [2:0] cause_o
);
    import irq_guard_pkg::*;

    logic   in_reset, wd_en, lat_en, wd_exp, lat_exp, restart;
    logic   nmi_fire, nmi_abort, nmi_active;
    cause_t cause_set, cause_q;

    assign wd_en   = !sup_mode_i && !kick_i && !in_reset;
    assign lat_en  = !irq_n_i && !sup_mode_i && !in_reset;
    assign restart = wd_exp || lat_exp;

    irq_guard_counter #(.LIMIT(WDOG_CYCLES)) wd_cnt_i (
        .clk(clk), .rst_n(rst_n), .en(wd_en), .restart(restart), .expire(wd_exp)
    );

    irq_guard_counter #(.LIMIT(LAT_CYCLES)) lat_cnt_i (
        .clk(clk), .rst_n(rst_n), .en(lat_en), .restart(restart), .expire(lat_exp)
    );

    irq_guard_fsm #(.RST_CYCLES(RST_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .wd_exp(wd_exp), .lat_exp(lat_exp), .kick(kick_i),
        .in_reset(in_reset), .nmi_fire(nmi_fire), .nmi_abort(nmi_abort),
        .cause_set(cause_set)
    );

    irq_guard_pulse #(.LEN(NMI_CYCLES)) nmi_pulse_i (
        .clk(clk), .rst_n(rst_n), .start(nmi_fire), .abort(nmi_abort),
        .active(nmi_active)
    );

    irq_guard_cause cause_i (
        .clk(clk), .rst_n(rst_n), .sup(sup_mode_i), .clr_req(cause_clr_i),
        .set(cause_set), .cause(cause_q)
    );

    assign nmi_n_o = !nmi_active;
    assign rst_n_o = !in_reset;
    assign cause_o = cause_q;

endmodule

// File: rtl/irq_guard_chk.sv
module irq_guard_chk #(
    parameter int RST_CYCLES = 16,
    parameter int NMI_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_mode_i,
    input logic       irq_n_i,
    input logic       nmi_n_o,
    input logic       rst_n_o,
    input logic [2:0] cause_o
);
    logic [31:0] rst_low_len, nmi_low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_low_len <= '0;
            nmi_low_len <= '0;
        end else begin
            rst_low_len <= rst_n_o ? 32'd0 : rst_low_len + 32'd1;
            nmi_low_len <= nmi_n_o ? 32'd0 : nmi_low_len + 32'd1;
        end
    end

    AST_NMI_NOT_FROM_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n_o) |-> !$past(sup_mode_i)); // R1

    AST_NMI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nmi_n_o) && rst_n_o) |-> (nmi_low_len == 32'(NMI_CYCLES))); // R3

    AST_LAT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_o[2]) |-> $past(!irq_n_i && !sup_mode_i)); // R5

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> (rst_low_len == 32'(RST_CYCLES))); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R8

    AST_NO_NMI_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_o |-> nmi_n_o); // R9

endmodule

bind irq_guard irq_guard_chk #(
    .RST_CYCLES(RST_CYCLES),
    .NMI_CYCLES(NMI_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sup_mode_i(sup_mode_i), .irq_n_i(irq_n_i),
    .nmi_n_o(nmi_n_o), .rst_n_o(rst_n_o), .cause_o(cause_o)
);

// File: tb/irq_guard_tb_top.sv
module irq_guard_tb_top;
    localparam int WD   = 40;
    localparam int LAT  = 12;
    localparam int RSTP = 5;
    localparam int NMIP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b1, irq_n = 1'b1, kick = 1'b0, cclr = 1'b0;
    logic nmi_n, rst_n_o;
    logic [2:0] cause;

    irq_guard #(.WDOG_CYCLES(WD), .LAT_CYCLES(LAT), .RST_CYCLES(RSTP), .NMI_CYCLES(NMIP)) dut_i (
        .clk(clk), .rst_n(rst_n), .sup_mode_i(sup), .irq_n_i(irq_n), .kick_i(kick),
        .cause_clr_i(cclr), .nmi_n_o(nmi_n), .rst_n_o(rst_n_o), .cause_o(cause)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 0 = NMI edge, 1 = reset edge
        int    at;
        int    len;
        string req;
    } ev_t;
    ev_t expq[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input int len, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.len = len; e.req = req;
        expq.push_back(e);
    endtask

    // Monitor: pops expected edges and compares as they appear
    bit prev_n = 1'b1, prev_r = 1'b1;
    int start_n, start_r, len_n, len_r;
    string req_n, req_r;

    task automatic take_edge(input int kind, output int len, output string req);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R1", "unexpected edge kind", kind, -1);
            len = -1; req = "R1";
        end else begin
            e = expq.pop_front();
            chk(e.kind == kind, e.req, "edge kind", kind, e.kind);
            chk(cyc == e.at, e.req, "edge cycle", cyc, e.at);
            len = e.len; req = e.req;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_n && !nmi_n) begin start_n = cyc; take_edge(0, len_n, req_n); end
            if (!prev_n && nmi_n && len_n >= 0) chk(cyc - start_n == len_n, req_n, "nmi width", cyc - start_n, len_n);
            if (prev_r && !rst_n_o) begin start_r = cyc; take_edge(1, len_r, req_r); end
            if (!prev_r && rst_n_o && len_r >= 0) chk(cyc - start_r == len_r, "R6", "reset width", cyc - start_r, len_r);
            prev_n = nmi_n;
            prev_r = rst_n_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic check_cause(input logic [2:0] exp, input string req);
        chk(cause == exp, req, "cause", int'(cause), int'(exp));
    endtask

    task automatic clear_cause();
        sup = 1'b1; cclr = 1'b1; step(1); cclr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int d;
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state
        chk(nmi_n == 1'b1, "R3", "nmi idle after reset", int'(nmi_n), 1);
        chk(rst_n_o == 1'b1, "R6", "reset idle after reset", int'(rst_n_o), 1);
        check_cause(3'b000, "R8");

        // R1: supervisor mode with IRQ pending, no edges
        irq_n = 1'b0;
        step(3 * WD);
        irq_n = 1'b1;
        chk(expq.size() == 0 && nmi_n && rst_n_o, "R1", "quiet in supervisor", int'(nmi_n), 1);

        // R2: user mode with regular kicks, no edges
        sup = 1'b0;
        for (int i = 0; i < 5 * WD; i++) begin
            kick = (i % 30 == 0);
            step(1);
        end
        kick = 1'b0;
        sup = 1'b1;
        step(2);
        chk(nmi_n && rst_n_o, "R2", "quiet with kicks", int'(nmi_n), 1);

        // R3/R4: no kick, NMI then reset; cause survives forced reset
        d = cyc;
        sup = 1'b0;
        expect_ev(0, d + WD, NMIP, "R3");
        expect_ev(1, d + 2 * WD, RSTP, "R4");
        wait_to(d + WD + NMIP + 1);
        check_cause(3'b001, "R8");
        wait_to(d + 2 * WD);
        sup = 1'b1;
        wait_to(d + 2 * WD + RSTP + 2);
        check_cause(3'b011, "R8");

        // R8: clear ignored in user mode, honoured in supervisor mode
        sup = 1'b0; cclr = 1'b1; step(1);
        cclr = 1'b0; sup = 1'b1;
        check_cause(3'b011, "R8");
        cclr = 1'b1; step(1); cclr = 1'b0;
        check_cause(3'b000, "R8");

        // R6/R4: after reset machine is ARMED; kick de-escalates
        d = cyc;
        sup = 1'b0;
        expect_ev(0, d + WD, NMIP, "R6");
        wait_to(d + WD + 10);
        d = cyc;
        kick = 1'b1; step(1); kick = 1'b0;
        expect_ev(0, d + 1 + WD, NMIP, "R4");
        wait_to(d + 1 + WD);
        sup = 1'b1;
        // R4: supervisor time keeps escalation
        step(50);
        clear_cause();
        d = cyc;
        sup = 1'b0;
        expect_ev(1, d + WD, RSTP, "R4");
        wait_to(d + WD);
        sup = 1'b1;
        wait_to(d + WD + RSTP + 2);
        check_cause(3'b010, "R8");

        // R5: pending IRQ in user mode forces reset
        clear_cause();
        d = cyc;
        sup = 1'b0; irq_n = 1'b0;
        expect_ev(1, d + LAT, RSTP, "R5");
        while (cyc < d + LAT) begin
            kick = ((cyc - d) % 5 == 0);
            step(1);
        end
        kick = 1'b0; sup = 1'b1; irq_n = 1'b1;
        wait_to(d + LAT + RSTP + 2);
        check_cause(3'b100, "R5");

        // R5: counter restarts when IRQ drops
        clear_cause();
        sup = 1'b0;
        for (int i = 0; i < 5 * (LAT - 1); i++) begin
            irq_n = ((i % (LAT - 1)) == LAT - 2);
            kick = (i % 5 == 0);
            step(1);
        end
        irq_n = 1'b1; kick = 1'b0; sup = 1'b1;
        step(2);
        chk(nmi_n && rst_n_o, "R5", "quiet with IRQ gaps", int'(rst_n_o), 1);
        check_cause(3'b000, "R5");

        // R9: both expire together in ARMED, reset only
        clear_cause();
        d = cyc;
        sup = 1'b0;
        expect_ev(1, d + WD, RSTP, "R9");
        wait_to(d + WD - LAT);
        irq_n = 1'b0;
        wait_to(d + WD);
        sup = 1'b1; irq_n = 1'b1;
        wait_to(d + WD + RSTP + 2);
        check_cause(3'b100, "R9");

        // R7: NMI restarts the latency timer
        clear_cause();
        d = cyc;
        sup = 1'b0;
        expect_ev(0, d + WD, NMIP, "R7");
        expect_ev(1, d + WD + LAT, RSTP, "R7");
        wait_to(d + WD - LAT + 3);
        irq_n = 1'b0;
        wait_to(d + WD + LAT);
        sup = 1'b1; irq_n = 1'b1;
        wait_to(d + WD + LAT + RSTP + 2);
        check_cause(3'b101, "R7");

        step(5);
        chk(expq.size() == 0, "R7", "expected edges left", expq.size(), 0);
        finish_run();
    end

endmodule